// File: doc/BRIEF.md
# Write Drain Arbiter

This block chooses, cycle by cycle, whether a memory channel is serving reads or writes. It sees the occupancy of a read request queue and a write request queue as plain counts, plus a strobe each time a write is enqueued. Once a write arrives and pushes the write queue to a high mark, the block switches into a drain mode. In that mode read issue is blocked, and the block issues writes one at a time.

Each drained write is handed off by a one-cycle issue strobe. The block then waits for the write queue to confirm the dequeue before it judges whether draining should continue. Draining ends when the write queue is empty. It also ends when the queue has fallen to a low mark while reads are waiting. The two marks act as hysteresis.

The block keeps a free-running cycle count and a bus-busy-until time. Every access pushes the bus-busy-until time forward by one burst. From it the block derives the earliest start for the next request, pulled forward by the row-miss latency. Leaving drain mode adds a write-to-read turnaround to the bus time. Reads are allowed again only once the cycle count reaches that new time.

Top module: `wr_drain_arb`

## Requirements
- R1: While reset is held, `drain`, `wr_issue`, `rd_allow`, `next_time` and `drain_writes` are all zero.
- R2: Drain mode (`drain`=1) is entered on the clock edge where, in read mode, `wr_enq` is 1 and `wr_count` is at least HI = floor(WQ_DEPTH*HI_PCT/100). A count at or above HI without `wr_enq` does not enter, and neither does `wr_enq` with a count below HI.
- R3: `rd_allow` is 0 in every cycle where `drain` is 1.
- R4: `wr_issue` is a single-cycle pulse and is only given in drain mode. After a pulse, no further pulse comes until `wr_deq` has been seen and one decision cycle has passed.
- R5: A write is issued on an edge only if the cycle count at that edge is at least the `next_time` held before it.
- R6: At a decision, an empty write queue ends drain mode whatever `rd_count` is.
- R7: At a decision, a `wr_count` at or below LO = floor(WQ_DEPTH*LO_PCT/100) ends drain mode only when `rd_count` is nonzero. With no reads waiting, draining continues down to an empty queue.
- R8: `drain_writes` counts the writes issued in the current drain period. It is cleared on the edge that leaves drain mode.
- R9: Each issued access at cycle t sets busy = max(busy, t) + T_BURST. It also sets `next_time` to busy − L when busy exceeds L and busy − L exceeds t, and to t otherwise, with L = T_RP + T_RCD + T_CL.
- R10: Leaving drain mode adds T_WTR to busy and sets `next_time` to the new busy value. In read mode, `rd_allow` is 1 exactly when the cycle count is at least `next_time`.
- R11: The cycle count is 0 during reset and increases by one on every edge after it. A read counts as issued when `rd_issued` and `rd_allow` are both 1 at an edge in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_count | input | WQ_CW | Write queue occupancy |
| rd_count | input | RQ_CW | Read queue occupancy |
| wr_enq | input | 1 | A write was enqueued this cycle |
| wr_deq | input | 1 | Write queue confirms removal of the issued write |
| rd_issued | input | 1 | Downstream issued a read this cycle |
| drain | output | 1 | 1 while in write-drain mode |
| wr_issue | output | 1 | One-cycle pulse per issued write |
| rd_allow | output | 1 | Reads may be issued |
| next_time | output | TIME_W | Earliest cycle for the next request |
| drain_writes | output | CNT_W | Writes issued in the current drain period |

## Verification
The bench targets three areas. It probes the entry edge with one count below the high mark, the mark reached without an enqueue, and the mark reached with an enqueue. A design using a strict comparison or ignoring the enqueue strobe would enter drain mode early or late. It runs drains with reads waiting, with none waiting, and with reads arriving below the low mark. The issued write totals expose an exit test that ignores the read queue or treats the low mark as exclusive. A cycle-level model tracks the bus time across back-to-back writes and reads and after each mode exit. A missing turnaround, a missing row-miss pull-in, or a write launched before its due time shows up as a wrong `next_time` or an early `rd_allow`.

// File: rtl/wr_drain_pkg.sv
package wr_drain_pkg;

  // Arbiter phases: serving reads, waiting for a write slot,
  // waiting for the queue to confirm removal, judging whether to continue.
  typedef enum logic [1:0] {
    PH_READ   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_ACK    = 2'd2,
    PH_DECIDE = 2'd3
  } drain_phase_t;

  // Entry count that a percentage of a queue depth covers, fraction dropped.
  function automatic int pct_entries(input int depth, input int pct);
    return (depth * pct) / 100;
  endfunction

endpackage

// File: rtl/wr_drain_timer.sv
module wr_drain_timer #(
  parameter int TIME_W  = 32,
  parameter int T_BURST = 4,
  parameter int T_WTR   = 6,
  parameter int T_RP    = 14,
  parameter int T_RCD   = 14,
  parameter int T_CL    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              turn,
  output logic [TIME_W-1:0] now_q,
  output logic [TIME_W-1:0] next_q,
  output logic [TIME_W-1:0] now_d,
  output logic [TIME_W-1:0] next_d,
  output logic              due
);

  localparam logic [TIME_W-1:0] ROW_MISS = TIME_W'(T_RP + T_RCD + T_CL);
  localparam logic [TIME_W-1:0] BURST    = TIME_W'(T_BURST);
  localparam logic [TIME_W-1:0] WTR      = TIME_W'(T_WTR);

  logic [TIME_W-1:0] busy_q, busy_d;
  logic [TIME_W-1:0] start, bus_end, pulled;

  always_comb begin
    now_d   = now_q + 1'b1;
    start   = (busy_q > now_q) ? busy_q : now_q;
    bus_end = start + BURST;
    pulled  = bus_end - ROW_MISS;
    busy_d  = busy_q;
    next_d  = next_q;
    if (take) begin
      busy_d = bus_end;
      next_d = ((bus_end > ROW_MISS) && (pulled > now_q)) ? pulled : now_q;
    end else if (turn) begin
      busy_d = busy_q + WTR;
      next_d = busy_q + WTR;
    end
  end

  assign due = (now_q >= next_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q  <= '0;
      busy_q <= '0;
      next_q <= '0;
    end else begin
      now_q  <= now_d;
      busy_q <= busy_d;
      next_q <= next_d;
    end
  end

endmodule

// File: rtl/wr_drain_fsm.sv
module wr_drain_fsm
  import wr_drain_pkg::*;
#(
  parameter int WQ_CW   = 6,
  parameter int RQ_CW   = 6,
  parameter int CNT_W   = 8,
  parameter int HI_MARK = 22,
  parameter int LO_MARK = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WQ_CW-1:0] wr_count,
  input  logic [RQ_CW-1:0] rd_count,
  input  logic             wr_enq,
  input  logic             wr_deq,
  input  logic             rd_issued,
  input  logic             rd_allow,
  input  logic             due,
  output logic             take,
  output logic             turn,
  output logic             read_mode_d,
  output logic             drain_q,
  output logic             issue_q,
  output logic [CNT_W-1:0] writes_q
);

  localparam logic [WQ_CW-1:0] HI = WQ_CW'(HI_MARK);
  localparam logic [WQ_CW-1:0] LO = WQ_CW'(LO_MARK);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  drain_phase_t ph_q, ph_d;
  logic             issue_d;
  logic [CNT_W-1:0] writes_d;
  logic             release_now;

  assign release_now = (wr_count == '0) ||
                       ((wr_count <= LO) && (rd_count != '0));

  always_comb begin
    ph_d     = ph_q;
    take     = 1'b0;
    turn     = 1'b0;
    issue_d  = 1'b0;
    writes_d = writes_q;
    unique case (ph_q)
      PH_READ: begin
        take = rd_issued && rd_allow;
        if (wr_enq && (wr_count >= HI)) ph_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (due) begin
          take     = 1'b1;
          issue_d  = 1'b1;
          writes_d = (writes_q == CNT_MAX) ? writes_q : writes_q + 1'b1;
          ph_d     = PH_ACK;
        end
      end
      PH_ACK: begin
        if (wr_deq) ph_d = PH_DECIDE;
      end
      PH_DECIDE: begin
        if (release_now) begin
          turn     = 1'b1;
          writes_d = '0;
          ph_d     = PH_READ;
        end else begin
          ph_d = PH_WAIT;
        end
      end
      default: ph_d = PH_READ;
    endcase
  end

  assign read_mode_d = (ph_d == PH_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_READ;
      drain_q  <= 1'b0;
      issue_q  <= 1'b0;
      writes_q <= '0;
    end else begin
      ph_q     <= ph_d;
      drain_q  <= (ph_d != PH_READ);
      issue_q  <= issue_d;
      writes_q <= writes_d;
    end
  end

endmodule

// File: rtl/wr_drain_arb.sv
module wr_drain_arb
  import wr_drain_pkg::*;
#(
  parameter int WQ_DEPTH = 32,
  parameter int RQ_DEPTH = 32,
  parameter int HI_PCT   = 70,
  parameter int LO_PCT   = 0,
  parameter int TIME_W   = 32,
  parameter int T_BURST  = 4,
  parameter int T_WTR    = 6,
  parameter int T_RP     = 14,
  parameter int T_RCD    = 14,
  parameter int T_CL     = 14,
  localparam int WQ_CW   = $clog2(WQ_DEPTH + 1),
  localparam int RQ_CW   = $clog2(RQ_DEPTH + 1),
  localparam int CNT_W   = WQ_CW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WQ_CW-1:0]  wr_count,
  input  logic [RQ_CW-1:0]  rd_count,
  input  logic              wr_enq,
  input  logic              wr_deq,
  input  logic              rd_issued,
  output logic              drain,
  output logic              wr_issue,
  output logic              rd_allow,
  output logic [TIME_W-1:0] next_time,
  output logic [CNT_W-1:0]  drain_writes
);

  localparam int HI_MARK = pct_entries(WQ_DEPTH, HI_PCT);
  localparam int LO_MARK = pct_entries(WQ_DEPTH, LO_PCT);

  logic              take, turn, due, read_mode_d;
  logic [TIME_W-1:0] now, now_d, next_d;

  wr_drain_timer #(
    .TIME_W (TIME_W),
    .T_BURST(T_BURST),
    .T_WTR  (T_WTR),
    .T_RP   (T_RP),
    .T_RCD  (T_RCD),
    .T_CL   (T_CL)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .turn  (turn),
    .now_q (now),
    .next_q(next_time),
    .now_d (now_d),
    .next_d(next_d),
    .due   (due)
  );

  wr_drain_fsm #(
    .WQ_CW  (WQ_CW),
    .RQ_CW  (RQ_CW),
    .CNT_W  (CNT_W),
    .HI_MARK(HI_MARK),
    .LO_MARK(LO_MARK)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_count   (wr_count),
    .rd_count   (rd_count),
    .wr_enq     (wr_enq),
    .wr_deq     (wr_deq),
    .rd_issued  (rd_issued),
    .rd_allow   (rd_allow),
    .due        (due),
    .take       (take),
    .turn       (turn),
    .read_mode_d(read_mode_d),
    .drain_q    (drain),
    .issue_q    (wr_issue),
    .writes_q   (drain_writes)
  );

  // Reads open only in read mode and once the cycle count reaches the
  // earliest-request time; registered from next-cycle values.
  always_ff @(posedge clk) begin
    if (rst) rd_allow <= 1'b0;
    else     rd_allow <= read_mode_d && (now_d >= next_d);
  end

endmodule

// File: rtl/wr_drain_arb_chk.sv
module wr_drain_arb_chk #(
  parameter int WQ_CW   = 6,
  parameter int CNT_W   = 8,
  parameter int TIME_W  = 32,
  parameter int HI_MARK = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              drain,
  input logic              wr_issue,
  input logic              rd_allow,
  input logic              wr_enq,
  input logic              wr_deq,
  input logic [WQ_CW-1:0]  wr_count,
  input logic [TIME_W-1:0] now,
  input logic [TIME_W-1:0] next_time,
  input logic [CNT_W-1:0]  drain_writes
);

  AST_NO_READ_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
    drain |-> !rd_allow); // R3

  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_issue |=> !wr_issue); // R4

  AST_ISSUE_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
    wr_issue |-> drain); // R4

  AST_ISSUE_WHEN_DUE: assert property (@(posedge clk) disable iff (rst)
    wr_issue |-> ($past(now) >= $past(next_time))); // R5

  AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(drain) |-> ($past(wr_enq) && ($past(wr_count) >= WQ_CW'(HI_MARK)))); // R2

  AST_EXIT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(drain) |-> (drain_writes == '0)); // R8

  AST_READ_GATE: assert property (@(posedge clk) disable iff (rst)
    rd_allow |-> (now >= next_time)); // R10

  AST_COUNT_STEADY_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (drain && $past(drain) && !wr_issue) |-> $stable(drain_writes)); // R8

endmodule

bind wr_drain_arb wr_drain_arb_chk #(
  .WQ_CW  (WQ_CW),
  .CNT_W  (CNT_W),
  .TIME_W (TIME_W),
  .HI_MARK(HI_MARK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .drain       (drain),
  .wr_issue    (wr_issue),
  .rd_allow    (rd_allow),
  .wr_enq      (wr_enq),
  .wr_deq      (wr_deq),
  .wr_count    (wr_count),
  .now         (now),
  .next_time   (next_time),
  .drain_writes(drain_writes)
);

// File: tb/wr_drain_arb_bench.sv
module wr_drain_arb_bench;

  localparam int WQ_DEPTH = 32;
  localparam int RQ_DEPTH = 32;
  localparam int HI_PCT   = 70;
  localparam int LO_PCT   = 25;
  localparam int TIME_W   = 32;
  localparam int T_BURST  = 8;
  localparam int T_WTR    = 5;
  localparam int T_RP     = 2;
  localparam int T_RCD    = 2;
  localparam int T_CL     = 2;
  localparam int WQ_CW    = $clog2(WQ_DEPTH + 1);
  localparam int RQ_CW    = $clog2(RQ_DEPTH + 1);
  localparam int CNT_W    = WQ_CW + 2;
  localparam int HI       = (WQ_DEPTH * HI_PCT) / 100;  // 22
  localparam int LO       = (WQ_DEPTH * LO_PCT) / 100;  // 8
  localparam int LAT      = T_RP + T_RCD + T_CL;
  localparam int WD_LIMIT = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [WQ_CW-1:0]  wr_count = '0;
  logic [RQ_CW-1:0]  rd_count = '0;
  logic              wr_enq = 1'b0;
  logic              wr_deq = 1'b0;
  logic              rd_issued = 1'b0;
  logic              drain, wr_issue, rd_allow;
  logic [TIME_W-1:0] next_time;
  logic [CNT_W-1:0]  drain_writes;

  int total = 0;
  int bad   = 0;
  int unsigned cyc = 0;
  int unsigned m_bb = 0;
  int unsigned m_nt = 0;
  int unsigned m_cnt = 0;
  logic rd_took = 1'b0;
  logic prev_drain = 1'b0;
  int wd = 0;

  always #2 clk = ~clk;  // 250 MHz

  wr_drain_arb #(
    .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT),
    .TIME_W(TIME_W), .T_BURST(T_BURST), .T_WTR(T_WTR),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)
  ) u_wr_drain_arb (
    .clk(clk), .rst(rst), .wr_count(wr_count), .rd_count(rd_count),
    .wr_enq(wr_enq), .wr_deq(wr_deq), .rd_issued(rd_issued),
    .drain(drain), .wr_issue(wr_issue), .rd_allow(rd_allow),
    .next_time(next_time), .drain_writes(drain_writes)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Bench-side bus model (R9)
  task automatic model_access(input int unsigned t);
    int unsigned s;
    s    = (m_bb > t) ? m_bb : t;
    m_bb = s + T_BURST;
    m_nt = ((m_bb > LAT) && (m_bb - LAT > t)) ? m_bb - LAT : t;
  endtask

  // R11: cycle count mirror; read acceptance mirror
  always @(posedge clk) begin
    cyc     <= rst ? 0 : cyc + 1;
    rd_took <= !rst && rd_issued && rd_allow && !drain;
  end

  // Cycle monitor: timing, counters and read gating
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      if (wr_issue) begin
        chk((cyc - 1) >= m_nt, "R5", cyc - 1, m_nt);
        m_cnt++;
        model_access(cyc - 1);
        chk(next_time == m_nt, "R9", next_time, m_nt);
        chk(drain_writes == m_cnt, "R8", drain_writes, m_cnt);
      end
      if (rd_took) begin
        model_access(cyc - 1);
        chk(next_time == m_nt, "R9", next_time, m_nt);
      end
      if (prev_drain && !drain) begin
        m_bb  = m_bb + T_WTR;
        m_nt  = m_bb;
        m_cnt = 0;
        chk(next_time == m_nt, "R10", next_time, m_nt);
        chk(drain_writes == 0, "R8", drain_writes, 0);
      end
      if (drain) chk(!rd_allow, "R3", rd_allow, 0);
      else       chk(rd_allow == (cyc >= m_nt), "R10", rd_allow, cyc >= m_nt);
      prev_drain = drain;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", wd, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic enq_at(input int n);
    @(posedge clk); #1;
    wr_count = WQ_CW'(n);
    wr_enq   = 1'b1;
    @(posedge clk); #1;
    wr_enq   = 1'b0;
    @(negedge clk);
  endtask

  // Serve a drain; rd_count becomes rd_late when the queue reaches at_level
  task automatic serve_drain(output int issued, input int at_level, input int rd_late);
    int wq;
    wq = int'(wr_count);
    issued = 0;
    while (drain) begin
      @(negedge clk);
      if (wr_issue) begin
        issued++;
        @(posedge clk); #1;
        wr_deq   = 1'b1;
        wq       = wq - 1;
        wr_count = WQ_CW'(wq);
        if (wq == at_level) rd_count = RQ_CW'(rd_late);
        @(posedge clk); #1;
        wr_deq   = 1'b0;
      end
    end
  endtask

  task automatic issue_reads(input int n);
    int k;
    k = 0;
    while (k < n) begin
      @(posedge clk); #1;
      if (rd_allow) begin
        rd_issued = 1'b1;
        k++;
      end else begin
        rd_issued = 1'b0;
      end
    end
    @(posedge clk); #1;
    rd_issued = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(drain == 0, "R1", drain, 0);
    chk(wr_issue == 0, "R1", wr_issue, 0);
    chk(rd_allow == 0, "R1", rd_allow, 0);
    chk(next_time == 0, "R1", next_time, 0);
    chk(drain_writes == 0, "R1", drain_writes, 0);
  endtask

  task automatic t_entry;
    enq_at(HI - 1);
    chk(drain == 0, "R2 below mark", drain, 0);
    @(posedge clk); #1;
    wr_count = WQ_CW'(HI);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(drain == 0, "R2 no enqueue", drain, 0);
    rd_count = RQ_CW'(3);
    enq_at(HI);
    chk(drain == 1, "R2 enter at mark", drain, 1);
    chk(rd_allow == 0, "R3 on entry", rd_allow, 0);
  endtask

  task automatic t_drain_reads_waiting;
    int n;
    serve_drain(n, -1, 0);
    chk(n == HI - LO, "R7 low mark with reads", n, HI - LO);
    chk(int'(wr_count) == LO, "R7 stop level", wr_count, LO);
    chk(rd_allow == 0, "R10 turnaround gap", rd_allow, 0);
  endtask

  task automatic t_reads_after;
    issue_reads(4);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(drain == 0, "R11 stays in read mode", drain, 0);
  endtask

  task automatic t_drain_no_reads;
    int n;
    @(posedge clk); #1;
    rd_count = '0;
    enq_at(HI);
    chk(drain == 1, "R2 re-entry", drain, 1);
    serve_drain(n, -1, 0);
    chk(n == HI, "R6 drains to empty", n, HI);
    chk(wr_count == 0, "R6 empty at exit", wr_count, 0);
  endtask

  task automatic t_reads_arrive_late;
    int n;
    repeat (30) @(posedge clk);
    #1;
    enq_at(HI);
    chk(drain == 1, "R2 third entry", drain, 1);
    serve_drain(n, 5, 1);
    chk(n == HI - 5, "R7 late read releases", n, HI - 5);
    chk(int'(wr_count) == 5, "R7 release level", wr_count, 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (4) @(posedge clk);
    t_entry;
    t_drain_reads_waiting;
    t_reads_after;
    t_drain_no_reads;
    t_reads_arrive_late;
    issue_reads(3);
    repeat (10) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule